// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a synchronous controller for a single-item vending machine. A control state machine sits beside a small credit datapath. Each clock cycle the block samples a two-bit coin code, adds the coin's value to an 8-bit credit register, and compares the running total against a fixed item price of 35 cents.

When a coin brings the credit to the price or above, the block raises a dispense strobe for one cycle. In the following cycle it presents the overpayment on a change bus. After that it clears the credit and waits for the next customer. Coins that arrive while a sale is being completed are not credited.

An inactivity counter discards a partial credit that sits untouched too long and returns the controller to its idle state. Coin inputs are expected to be already debounced and synchronised to `clk`, with one code presented per coin.

Top module: `coin_vendor`

## Requirements
- R1: Coin code 2'b01 adds 5, 2'b10 adds 10 and 2'b11 adds 25 to the credit; the new total appears on `credit_out` in the cycle after the code is sampled. Code 2'b00 adds nothing.
- R2: When a credited coin makes the total 35 or more, `vend_pulse` is high for exactly one cycle, the cycle after that coin is sampled. It is low in every other cycle and never stays high for the same purchase.
- R3: In the cycle after `vend_pulse`, `change_out` equals the credit minus 35. In every other cycle `change_out` is zero.
- R4: The credit total stays on `credit_out` during the dispense cycle and the change cycle. It reads zero in the cycle that follows the change cycle.
- R5: Coin codes sampled during the dispense cycle or the change cycle are not credited.
- R6: With code 2'b00 held, no dispense occurs and neither the credit nor the change output moves, except through the inactivity timeout of R7.
- R7: While a partial credit is held, TIMEOUT_CYC consecutive cycles without a coin clear the credit. The clear is visible after the TIMEOUT_CYC-th such cycle. Every credited coin restarts this count.
- R8: A synchronous active-high `rst` sampled at a clock edge clears the credit, the dispense strobe and the change output, and returns the controller to idle from any state.
- R9: Three purchase sequences return the stated change: 25 then 10 returns 0, 25 then 25 returns 15, and four dimes return 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coin_code | input | 2 | Coin sampled this cycle: 00 none, 01 five, 10 ten, 11 twenty-five |
| vend_pulse | output | 1 | One-cycle dispense strobe |
| change_out | output | 8 | Overpayment, nonzero only in the change cycle |
| credit_out | output | 8 | Current accumulated credit |

## Verification
The hardest behaviour to reach from the ports is the exact edge of the inactivity window. It takes a run of coinless cycles with no stray code, and that run must end exactly one cycle before and one cycle at the limit. The bench shortens the timeout through the parameter and checks the credit after one cycle fewer than the limit and again after the limit. It then repeats the run with a coin inserted just before expiry, which shows that the count restarts. Ignored coins are reached by driving nonzero codes in the dispense and change cycles of a purchase, then reading the credit and change that follow.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_VEND    = 2'd2,
    ST_CHANGE  = 2'd3
  } vend_state_t;

  typedef enum logic [1:0] {
    CR_HOLD  = 2'd0,
    CR_ADD   = 2'd1,
    CR_CLEAR = 2'd2
  } credit_op_t;

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode #(
  parameter int CW          = 8,
  parameter int NICKEL_VAL  = 5,
  parameter int DIME_VAL    = 10,
  parameter int QUARTER_VAL = 25
) (
  input  logic [1:0]    coin_code,
  output logic [CW-1:0] coin_val,
  output logic          coin_seen
);

  localparam logic [CW-1:0] V_NICKEL  = CW'(NICKEL_VAL);
  localparam logic [CW-1:0] V_DIME    = CW'(DIME_VAL);
  localparam logic [CW-1:0] V_QUARTER = CW'(QUARTER_VAL);

  always_comb begin
    unique case (coin_code)
      2'b01:   coin_val = V_NICKEL;
      2'b10:   coin_val = V_DIME;
      2'b11:   coin_val = V_QUARTER;
      default: coin_val = '0;
    endcase
  end

  assign coin_seen = (coin_code != 2'b00);

endmodule

// File: rtl/vend_credit_dp.sv
module vend_credit_dp
  import vend_pkg::*;
#(
  parameter int CW    = 8,
  parameter int PRICE = 35
) (
  input  logic          clk,
  input  logic          rst,
  input  credit_op_t    op,
  input  logic [CW-1:0] coin_val,
  input  logic          vend_go,
  input  logic          in_vend,
  output logic          reach,
  output logic [CW-1:0] credit_q,
  output logic          vend_q,
  output logic [CW-1:0] change_q
);

  localparam logic [CW:0]   PRICE_WIDE = (CW+1)'(PRICE);
  localparam logic [CW-1:0] PRICE_NARR = CW'(PRICE);

  logic [CW:0] sum;

  assign sum   = {1'b0, credit_q} + {1'b0, coin_val};
  assign reach = (sum >= PRICE_WIDE);

  always_ff @(posedge clk) begin
    if (rst) begin
      credit_q <= '0;
      vend_q   <= 1'b0;
      change_q <= '0;
    end else begin
      unique case (op)
        CR_ADD:   credit_q <= sum[CW-1:0];
        CR_CLEAR: credit_q <= '0;
        default:  credit_q <= credit_q;
      endcase
      vend_q   <= vend_go;
      change_q <= in_vend ? (credit_q - PRICE_NARR) : '0;
    end
  end

endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
  import vend_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       coin_seen,
  input  logic       reach,
  output credit_op_t op,
  output logic       vend_go,
  output logic       in_vend
);

  localparam int            TW     = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

  vend_state_t   state_q, state_d;
  logic [TW-1:0] idle_cnt_q;
  logic          expire;

  assign expire = (state_q == ST_COLLECT) && !coin_seen && (idle_cnt_q == T_LAST);

  always_comb begin
    state_d = state_q;
    op      = CR_HOLD;
    vend_go = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_COLLECT: begin
        if (coin_seen) begin
          op = CR_ADD;
          if (reach) begin
            state_d = ST_VEND;
            vend_go = 1'b1;
          end else begin
            state_d = ST_COLLECT;
          end
        end else if (expire) begin
          op      = CR_CLEAR;
          state_d = ST_IDLE;
        end
      end
      ST_VEND:   state_d = ST_CHANGE;
      ST_CHANGE: begin
        op      = CR_CLEAR;
        state_d = ST_IDLE;
      end
      default: begin
        op      = CR_CLEAR;
        state_d = ST_IDLE;
      end
    endcase
  end

  assign in_vend = (state_q == ST_VEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      idle_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (coin_seen || state_q != ST_COLLECT || expire)
        idle_cnt_q <= '0;
      else
        idle_cnt_q <= idle_cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/coin_vendor.sv
module coin_vendor
  import vend_pkg::*;
#(
  parameter int CW          = 8,
  parameter int PRICE       = 35,
  parameter int NICKEL_VAL  = 5,
  parameter int DIME_VAL    = 10,
  parameter int QUARTER_VAL = 25,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    coin_code,
  output logic          vend_pulse,
  output logic [CW-1:0] change_out,
  output logic [CW-1:0] credit_out
);

  logic [CW-1:0] coin_val;
  logic          coin_seen;
  logic          reach;
  credit_op_t    op;
  logic          vend_go;
  logic          in_vend;

  vend_coin_decode #(
    .CW(CW), .NICKEL_VAL(NICKEL_VAL), .DIME_VAL(DIME_VAL), .QUARTER_VAL(QUARTER_VAL)
  ) u_dec (
    .coin_code(coin_code),
    .coin_val (coin_val),
    .coin_seen(coin_seen)
  );

  vend_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .coin_seen(coin_seen),
    .reach    (reach),
    .op       (op),
    .vend_go  (vend_go),
    .in_vend  (in_vend)
  );

  vend_credit_dp #(.CW(CW), .PRICE(PRICE)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .coin_val(coin_val),
    .vend_go (vend_go),
    .in_vend (in_vend),
    .reach   (reach),
    .credit_q(credit_out),
    .vend_q  (vend_pulse),
    .change_q(change_out)
  );

endmodule

// File: rtl/vend_checker.sv
module vend_checker #(
  parameter int CW    = 8,
  parameter int PRICE = 35
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    coin_code,
  input logic          vend_pulse,
  input logic [CW-1:0] change_out,
  input logic [CW-1:0] credit_out
);

  localparam logic [CW-1:0] PRICE_C = CW'(PRICE);

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    vend_pulse |=> !vend_pulse); // R2

  AST_VEND_AT_PRICE: assert property (@(posedge clk) disable iff (rst)
    vend_pulse |-> credit_out >= PRICE_C); // R2

  AST_CHANGE_VALUE: assert property (@(posedge clk) disable iff (rst)
    vend_pulse |=> change_out == ($past(credit_out) - PRICE_C)); // R3

  AST_CHANGE_ONLY_AFTER_VEND: assert property (@(posedge clk) disable iff (rst)
    (change_out != '0) |-> $past(vend_pulse)); // R3

  AST_CREDIT_HELD: assert property (@(posedge clk) disable iff (rst)
    vend_pulse |=> $stable(credit_out)); // R4

  AST_CREDIT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(vend_pulse) |=> credit_out == '0); // R4

  AST_IGNORE_IN_VEND: assert property (@(posedge clk) disable iff (rst)
    (vend_pulse && coin_code != 2'b00) |=> credit_out == $past(credit_out)); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (credit_out == '0 && !vend_pulse && change_out == '0)); // R8

endmodule

bind coin_vendor vend_checker #(.CW(CW), .PRICE(PRICE)) u_vend_chk (
  .clk       (clk),
  .rst       (rst),
  .coin_code (coin_code),
  .vend_pulse(vend_pulse),
  .change_out(change_out),
  .credit_out(credit_out)
);

// File: tb/coin_vendor_bench.sv
module coin_vendor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TB_TIMEOUT = 12;
  localparam int NVEC       = 22;

  // vector: {coin[1:0], credit after, vend after, change after}
  localparam logic [18:0] VEC [NVEC] = '{
    {2'b11, 8'd25, 1'b0, 8'd0},   // R1 quarter
    {2'b10, 8'd35, 1'b1, 8'd0},   // R2 R9 reach price exactly
    {2'b00, 8'd35, 1'b0, 8'd0},   // R3 R4 change 0
    {2'b00, 8'd0,  1'b0, 8'd0},   // R4 cleared
    {2'b11, 8'd25, 1'b0, 8'd0},
    {2'b11, 8'd50, 1'b1, 8'd0},   // R2 R9 overpay
    {2'b01, 8'd50, 1'b0, 8'd15},  // R5 coin in vend ignored, R3 change 15
    {2'b10, 8'd0,  1'b0, 8'd0},   // R5 coin in change ignored
    {2'b10, 8'd10, 1'b0, 8'd0},
    {2'b10, 8'd20, 1'b0, 8'd0},
    {2'b00, 8'd20, 1'b0, 8'd0},   // R6 idle cycle
    {2'b10, 8'd30, 1'b0, 8'd0},
    {2'b10, 8'd40, 1'b1, 8'd0},   // R9 four dimes
    {2'b00, 8'd40, 1'b0, 8'd5},   // R3 change 5
    {2'b00, 8'd0,  1'b0, 8'd0},
    {2'b01, 8'd5,  1'b0, 8'd0},   // R1 nickel
    {2'b01, 8'd10, 1'b0, 8'd0},
    {2'b11, 8'd35, 1'b1, 8'd0},   // R2
    {2'b11, 8'd35, 1'b0, 8'd0},   // R5 ignored in vend
    {2'b01, 8'd0,  1'b0, 8'd0},   // R5 ignored in change
    {2'b00, 8'd0,  1'b0, 8'd0},   // R6 nothing moves
    {2'b01, 8'd5,  1'b0, 8'd0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] coin_code = 2'b00;
  logic       vend_pulse;
  logic [7:0] change_out;
  logic [7:0] credit_out;

  int checks   = 0;
  int failures = 0;

  coin_vendor #(.TIMEOUT_CYC(TB_TIMEOUT)) u_coin_vendor (
    .clk       (clk),
    .rst       (rst),
    .coin_code (coin_code),
    .vend_pulse(vend_pulse),
    .change_out(change_out),
    .credit_out(credit_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] c);
    coin_code = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(2'b11);                        // coin during reset
    rst = 1'b0;
    chk("R8 reset credit", credit_out, 0);
    chk("R8 reset vend", vend_pulse, 0);
    chk("R8 reset change", change_out, 0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][18:17]);
      chk("R1/R2/R9 vec credit", credit_out, VEC[i][16:9]);
      chk("R2 vec vend", vend_pulse, VEC[i][8]);
      chk("R3 vec change", change_out, VEC[i][7:0]);
    end

    // R7: credit 5 held, TB_TIMEOUT-1 idle cycles keep it
    idle(TB_TIMEOUT - 1);
    chk("R7 before timeout", credit_out, 5);
    chk("R6 no vend while idle", vend_pulse, 0);
    idle(1);
    chk("R7 at timeout", credit_out, 0);

    // R7 restart on coin
    step(2'b01);
    idle(TB_TIMEOUT - 1);
    step(2'b01);
    chk("R7 restart credit", credit_out, 10);
    idle(TB_TIMEOUT - 1);
    chk("R7 restarted window", credit_out, 10);
    idle(1);
    chk("R7 restarted expiry", credit_out, 0);

    // R8 reset during collect
    step(2'b11);
    rst = 1'b1;
    step(2'b00);
    rst = 1'b0;
    chk("R8 reset mid collect", credit_out, 0);

    // R8 reset during vend cycle
    step(2'b11);
    step(2'b11);
    chk("R2 vend before reset", vend_pulse, 1);
    rst = 1'b1;
    step(2'b00);
    rst = 1'b0;
    chk("R8 reset in vend credit", credit_out, 0);
    chk("R8 reset in vend change", change_out, 0);
    step(2'b00);
    chk("R8 no late change", change_out, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule